// File: doc/BRIEF.md
# Dual-Register Direct Digital Synthesizer

This block is a numerically controlled oscillator core. It keeps two 28-bit tuning words and two 12-bit phase offsets. Two select inputs pick one tuning word and one phase offset. Toggling a select input gives frequency-shift or phase-shift keying without a break in phase. On every master clock the chosen tuning word is added to a 28-bit accumulator. The output frequency is therefore f_clk × word / 2^28.

The top 12 accumulator bits plus the chosen offset form a 12-bit phase, so an offset of N shifts the wave by 2π·N/4096. That phase feeds either a quarter-wave sine table with symmetry folding or a linear ramp. The result is a 10-bit offset-binary amplitude word. A separate sign output carries either the top accumulator bit or the bit just below it. Two power-down inputs can each stop the accumulator or silence the amplitude path, or both together can do so. A parallel write port loads the four registers.

Top module: `dds_core`

## Requirements
- R1: When `clk_off` is low, each rising clock edge adds the tuning word chosen by `fsel` (0 picks register code 0, 1 picks code 1) to the 28-bit accumulator, modulo 2^28.
- R2: The 12-bit phase equals accumulator bits [27:16] plus the offset chosen by `psel` (0 picks code 2, 1 picks code 3), modulo 4096.
- R3: A write with `wr_en` high stores `wr_data` into the register given by `wr_sel`: 0 is tuning word A, 1 is tuning word B, 2 is offset A, 3 is offset B. Offsets take `wr_data[11:0]` and ignore the upper bits. The new value is used from the next edge on.
- R4: Changing `fsel` or `psel` never resets the accumulator, so the phase runs on continuously.
- R5: With `wave_ramp` high and `dac_off` low, `amp_out` equals phase bits [11:2], one cycle after the edge that sampled the accumulator.
- R6: With `wave_ramp` low and `dac_off` low, `amp_out` is offset binary and lies within 1 LSB of 511.5 + 511·sin(2π·(phase + 0.5)/4096).
- R7: `sign_out` is a registered copy of accumulator bit 27 when `sign_half` is 0, or of bit 26 when it is 1.
- R8: While `clk_off` is high, the accumulator holds its value.
- R9: While `dac_off` is high, `amp_out` is 0 from the next edge on, and `sign_out` keeps following R7.
- R10: A synchronous `rst` clears the accumulator and `sign_out` and sets `amp_out` to 512. It keeps the four registers, and writes made during reset are still stored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register code: 0/1 tuning words, 2/3 phase offsets |
| wr_data | input | 28 | Write data (offsets use bits 11:0) |
| fsel | input | 1 | Tuning word select |
| psel | input | 1 | Phase offset select |
| wave_ramp | input | 1 | 1 selects ramp, 0 selects sine |
| sign_half | input | 1 | 1 puts accumulator bit 26 on sign_out, 0 puts bit 27 |
| clk_off | input | 1 | Freezes the accumulator |
| dac_off | input | 1 | Forces the amplitude word to zero |
| amp_out | output | 10 | Amplitude word, offset binary |
| sign_out | output | 1 | Selected accumulator bit, registered |

## Verification
Register writes, select changes and accumulator steps all act at the edge that samples them. `amp_out` and `sign_out` are registered from the accumulator value held before that edge, so each result appears one cycle after its inputs are sampled. A change of tuning word therefore shows in the outputs two edges after the write. The reference model takes its inputs at each rising edge, updates in the same order and holds its expected outputs. The bench compares these with the ports at the following falling edge, when they are settled, and drives new stimulus just after that falling edge.

// File: rtl/dds_pkg.sv
package dds_pkg;

    typedef enum logic [1:0] {
        SEL_TUNE_A  = 2'd0,
        SEL_TUNE_B  = 2'd1,
        SEL_SHIFT_A = 2'd2,
        SEL_SHIFT_B = 2'd3
    } reg_sel_e;

    // Sine magnitude at the centre of quarter-wave slot idx, scaled to peak.
    // Evaluated at elaboration with a fixed-point Taylor series (Q30).
    function automatic int quarter_sine(int idx, int idx_w, int peak);
        longint x;
        longint x2;
        longint term;
        longint sum;
        x    = (64'sd3373259426 * longint'(2 * idx + 1)) >>> (idx_w + 2);
        x2   = (x * x) >>> 30;
        term = x;
        sum  = x;
        for (int k = 1; k <= 6; k++) begin
            term = -((term * x2) >>> 30) / longint'(2 * k * (2 * k + 1));
            sum  = sum + term;
        end
        return int'((sum * longint'(peak) + (64'sd1 <<< 29)) >>> 30);
    endfunction

endpackage

// File: rtl/dds_regfile.sv
module dds_regfile
    import dds_pkg::*;
#(
    parameter int FW = 28,
    parameter int PW = 12
) (
    input  logic                clk,
    input  logic                wr_en,
    input  logic [1:0]          wr_sel,
    input  logic [FW-1:0]       wr_data,
    output logic [1:0][FW-1:0]  tune_o,
    output logic [1:0][PW-1:0]  shift_o
);

    typedef struct packed {
        logic [1:0][FW-1:0] tune;
        logic [1:0][PW-1:0] shift;
    } regs_t;

    regs_t regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        if (wr_en) begin
            unique case (reg_sel_e'(wr_sel))
                SEL_TUNE_A:  regs_d.tune[0]  = wr_data;
                SEL_TUNE_B:  regs_d.tune[1]  = wr_data;
                SEL_SHIFT_A: regs_d.shift[0] = wr_data[PW-1:0];
                SEL_SHIFT_B: regs_d.shift[1] = wr_data[PW-1:0];
                default:     regs_d = regs_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        regs_q <= regs_d;
    end

    assign tune_o  = regs_q.tune;
    assign shift_o = regs_q.shift;

endmodule

// File: rtl/dds_sine_lut.sv
module dds_sine_lut
    import dds_pkg::*;
#(
    parameter int PH_W  = 12,
    parameter int AMP_W = 10
) (
    input  logic [PH_W-1:0]  phase_i,
    output logic [AMP_W-1:0] amp_o
);

    localparam int QW    = PH_W - 2;
    localparam int MAG_W = AMP_W - 1;
    localparam int PEAK  = (1 << MAG_W) - 1;
    localparam int DEPTH = 1 << QW;
    localparam logic [AMP_W-1:0] MID = AMP_W'(1 << MAG_W);

    logic [MAG_W-1:0] rom [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_rom
        localparam int VAL = quarter_sine(g, QW, PEAK);
        assign rom[g] = MAG_W'(VAL);
    end

    logic [QW-1:0]    slot;
    logic [MAG_W-1:0] mag;

    always_comb begin
        slot = phase_i[PH_W-2] ? ~phase_i[QW-1:0] : phase_i[QW-1:0];
        mag  = rom[slot];
        if (phase_i[PH_W-1]) begin
            amp_o = (MID - AMP_W'(1)) - AMP_W'(mag);
        end else begin
            amp_o = MID + AMP_W'(mag);
        end
    end

endmodule

// File: rtl/dds_core.sv
module dds_core #(
    parameter int ACC_W = 28,
    parameter int PH_W  = 12,
    parameter int AMP_W = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [1:0]       wr_sel,
    input  logic [ACC_W-1:0] wr_data,
    input  logic             fsel,
    input  logic             psel,
    input  logic             wave_ramp,
    input  logic             sign_half,
    input  logic             clk_off,
    input  logic             dac_off,
    output logic [AMP_W-1:0] amp_out,
    output logic             sign_out
);

    localparam logic [AMP_W-1:0] MID = AMP_W'(1 << (AMP_W - 1));

    typedef struct packed {
        logic [ACC_W-1:0] acc;
        logic [AMP_W-1:0] amp;
        logic             sign;
    } core_t;

    core_t st_d, st_q;

    logic [1:0][ACC_W-1:0] tune_w;
    logic [1:0][PH_W-1:0]  shift_w;
    logic [ACC_W-1:0]      tune_sel_w;
    logic [ACC_W-1:0]      acc_w;
    logic [PH_W-1:0]       phase_w;
    logic [AMP_W-1:0]      sine_w;

    dds_regfile #(.FW(ACC_W), .PW(PH_W)) u_regs (
        .clk     (clk),
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .wr_data (wr_data),
        .tune_o  (tune_w),
        .shift_o (shift_w)
    );

    assign acc_w      = st_q.acc;
    assign tune_sel_w = tune_w[fsel];
    assign phase_w    = st_q.acc[ACC_W-1 -: PH_W] + shift_w[psel];

    dds_sine_lut #(.PH_W(PH_W), .AMP_W(AMP_W)) u_lut (
        .phase_i (phase_w),
        .amp_o   (sine_w)
    );

    always_comb begin
        st_d = st_q;
        if (!clk_off) begin
            st_d.acc = st_q.acc + tune_sel_w;
        end
        st_d.sign = sign_half ? st_q.acc[ACC_W-2] : st_q.acc[ACC_W-1];
        if (dac_off) begin
            st_d.amp = '0;
        end else if (wave_ramp) begin
            st_d.amp = phase_w[PH_W-1 -: AMP_W];
        end else begin
            st_d.amp = sine_w;
        end
        if (rst) begin
            st_d.acc  = '0;
            st_d.amp  = MID;
            st_d.sign = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign amp_out  = st_q.amp;
    assign sign_out = st_q.sign;

endmodule

// File: rtl/dds_core_chk.sv
module dds_core_chk #(
    parameter int ACC_W = 28,
    parameter int AMP_W = 10
) (
    input logic             clk,
    input logic             rst,
    input logic             clk_off,
    input logic             dac_off,
    input logic             sign_half,
    input logic [ACC_W-1:0] acc_i,
    input logic [ACC_W-1:0] tune_i,
    input logic [AMP_W-1:0] amp_out,
    input logic             sign_out
);

    localparam logic [AMP_W-1:0] MID = AMP_W'(1 << (AMP_W - 1));

    AST_RESET_STATE: assert property (@(posedge clk)
        rst |=> (acc_i == '0) && (amp_out == MID) && !sign_out);  // R10

    AST_ACC_STEP: assert property (@(posedge clk) disable iff (rst)
        !clk_off |=> acc_i == $past(acc_i + tune_i));  // R1

    AST_ACC_HOLD: assert property (@(posedge clk) disable iff (rst)
        clk_off |=> acc_i == $past(acc_i));  // R8

    AST_DAC_SILENT: assert property (@(posedge clk) disable iff (rst)
        dac_off |=> amp_out == '0);  // R9

    AST_SIGN_TAP: assert property (@(posedge clk) disable iff (rst)
        sign_half |=> sign_out == $past(acc_i[ACC_W-2]));  // R7

    AST_SIGN_MSB: assert property (@(posedge clk) disable iff (rst)
        !sign_half |=> sign_out == $past(acc_i[ACC_W-1]));  // R7

endmodule

bind dds_core dds_core_chk #(.ACC_W(ACC_W), .AMP_W(AMP_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .clk_off   (clk_off),
    .dac_off   (dac_off),
    .sign_half (sign_half),
    .acc_i     (acc_w),
    .tune_i    (tune_sel_w),
    .amp_out   (amp_out),
    .sign_out  (sign_out)
);

// File: tb/test_dds_core.sv
module test_dds_core;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = 2'd0;
    logic [27:0] wr_data = '0;
    logic        fsel = 1'b0, psel = 1'b0, wave_ramp = 1'b1, sign_half = 1'b0;
    logic        clk_off = 1'b0, dac_off = 1'b0;
    logic [9:0]  amp_out;
    logic        sign_out;

    dds_core i_dds_core (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .fsel(fsel), .psel(psel), .wave_ramp(wave_ramp), .sign_half(sign_half),
        .clk_off(clk_off), .dac_off(dac_off), .amp_out(amp_out), .sign_out(sign_out)
    );

    always #10ns clk = ~clk;

    int    n_checks = 0;
    int    n_fail   = 0;
    bit    done     = 1'b0;
    string stage    = "R10";

    // reference model state
    longint m_acc = 0;
    longint m_tune [2] = '{0, 0};
    int     m_shift [2] = '{0, 0};
    bit     e_valid = 1'b0;
    int     e_kind;   // 0 zero, 1 mid, 2 ramp, 3 sine
    int     e_phase;
    bit     e_sign;
    string  e_stage, e_amp_tag, e_sign_tag;

    always @(posedge clk) begin
        e_valid = 1'b1;
        e_stage = stage;
        if (rst) begin
            e_kind = 1; e_sign = 1'b0; m_acc = 0;
            e_amp_tag = "R10"; e_sign_tag = "R10";
        end else begin
            e_phase = int'(((m_acc >> 16) + m_shift[psel]) % 4096);
            e_sign  = sign_half ? m_acc[26] : m_acc[27];
            e_sign_tag = clk_off ? "R8" : "R7";
            if (dac_off) begin e_kind = 0; e_amp_tag = "R9"; end
            else if (wave_ramp) begin e_kind = 2; e_amp_tag = "R5"; end
            else begin e_kind = 3; e_amp_tag = "R6"; end
            if (!clk_off) m_acc = (m_acc + m_tune[fsel]) % (64'sd1 << 28);
        end
        if (wr_en) begin
            if (wr_sel < 2) m_tune[wr_sel[0]] = longint'(wr_data);
            else m_shift[wr_sel[0]] = int'(wr_data[11:0]);
        end
    end

    always @(negedge clk) begin
        if (e_valid && !done) begin
            int ev, diff;
            real th;
            case (e_kind)
                0: ev = 0;
                1: ev = 512;
                2: ev = e_phase >> 2;
                default: begin
                    th = 2.0 * 3.14159265358979 * (real'(e_phase) + 0.5) / 4096.0;
                    ev = $rtoi(511.5 + 511.0 * $sin(th) + 0.5);
                end
            endcase
            diff = int'(amp_out) - ev;
            n_checks++;
            if ((e_kind == 3) ? (diff > 1 || diff < -1) : (diff != 0)) begin
                n_fail++;
                $display("FAIL %s/%s amp_out act=%0d exp=%0d (phase %0d)",
                         e_amp_tag, e_stage, amp_out, ev, e_phase);
            end
            n_checks++;
            if (sign_out !== e_sign) begin
                n_fail++;
                $display("FAIL %s/%s sign_out act=%0b exp=%0b", e_sign_tag, e_stage, sign_out, e_sign);
            end
        end
    end

    task automatic tick(int n);
        repeat (n) begin @(negedge clk); #1ns; end
    endtask

    task automatic wr(logic [1:0] sel, logic [27:0] data);
        wr_en = 1'b1; wr_sel = sel; wr_data = data;
        tick(1);
        wr_en = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(20ns * 150000);
        n_checks++; n_fail++;
        $display("FAIL watchdog expired act=running exp=finished");
        finish_run();
    end

    initial begin
        tick(1);
        // R10: registers written while reset is held are kept
        wr(2'd0, 28'h0100000);
        wr(2'd1, 28'h0347AE1);
        wr(2'd2, 28'h0000000);
        wr(2'd3, 28'h0000400);
        tick(2);
        rst = 1'b0; stage = "R1";
        tick(300);
        stage = "R3"; wr(2'd0, 28'h0FFFFFF); tick(50);
        stage = "R2"; wr(2'd2, 28'hABC012C); tick(50);
        stage = "R4"; fsel = 1'b1; tick(40); psel = 1'b1; tick(40);
        fsel = 1'b0; tick(40); psel = 1'b0; tick(20);
        stage = "R6"; wave_ramp = 1'b0; wr(2'd0, 28'h0123457); tick(600);
        fsel = 1'b1; psel = 1'b1; tick(200); fsel = 1'b0; psel = 1'b0;
        stage = "R7"; sign_half = 1'b1; tick(200);
        stage = "R1"; wave_ramp = 1'b1; wr(2'd0, 28'hFFFFFFF); tick(50);
        wr(2'd0, 28'h8000001); tick(50);
        stage = "R8"; wr(2'd0, 28'h0123457); clk_off = 1'b1; tick(30); clk_off = 1'b0; tick(10);
        stage = "R9"; dac_off = 1'b1; tick(30); clk_off = 1'b1; tick(30);
        clk_off = 1'b0; dac_off = 1'b0; tick(20);
        stage = "R10"; rst = 1'b1; tick(3); rst = 1'b0; wave_ramp = 1'b0; tick(150);
        finish_run();
    end

endmodule